// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block works out where a 32-bit load/store processor with fixed 4-byte instructions fetches next. Each cycle it takes the current program counter, a decoded control-transfer kind, the two register operands, the 16-bit immediate and the 26-bit jump field. On the following clock edge it registers the next fetch address, a flag that says whether control left the sequential path, and a link write that carries the return address for the return-address register.

The block handles five groups of transfers:

- two-register equality tests;
- sign and zero tests on one register;
- absolute jumps inside the current 256 MB region;
- jumps to an address held in a register;
- the linking forms of both kinds of jump.

No condition needs an adder. The equality tests compare bit patterns. The zero tests look only at the sign bit and an all-zero reduction.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next edge leaves `next_pc_o` at `RESET_PC` (default 0), `taken_o` at 0, `link_we_o` at 0 and `link_wdata_o` at 0.
- R2: Every output is registered. The outputs seen after a rising edge reflect the inputs sampled at that edge.
- R3: Kind code 0 (sequential) gives `next_pc_o = pc_i + 4` with `taken_o = 0` and `link_we_o = 0`.
- R4: Codes 1 to 6 are conditional branches. When the condition holds, `next_pc_o = pc_i + 4 + (sign-extended imm_i << 2)` and `taken_o = 1`. Otherwise `next_pc_o = pc_i + 4` and `taken_o = 0`.
- R5: Code 1 branches when `rs_val_i == rt_val_i`. Code 2 branches when they differ.
- R6: The zero tests act on `rs_val_i` read as signed. Code 3 branches when it is greater than 0, code 4 when it is 0 or more, code 5 when it is below 0, and code 6 when it is 0 or less.
- R7: Code 7 (direct jump) gives `next_pc_o = {pc_i+4 bits [31:28], jtarget_i, 2'b00}` with `taken_o = 1`.
- R8: Code 9 (register jump) gives `next_pc_o = rs_val_i` with `taken_o = 1`.
- R9: Code 8 (direct jump with link) and code 10 (register jump with link) reach the same targets as codes 7 and 9. They also set `link_we_o = 1`, `link_wdata_o = pc_i + 4` and `link_idx_o = 31`.
- R10: `link_we_o` is 1 only for codes 8 and 10. `taken_o` is 1 for every jump code (7 to 10).
- R11: The zero tests (codes 3 to 6) ignore `rt_val_i`. Changing it alters no output.
- R12: Codes 11 to 15 are unused and behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| kind_i | input | 4 | Decoded control-transfer kind (codes in R3 to R12) |
| rs_val_i | input | 32 | First register operand; also the register jump target |
| rt_val_i | input | 32 | Second register operand for the equality tests |
| imm_i | input | 16 | Signed branch offset in instruction words |
| jtarget_i | input | 26 | Direct jump word-target field |
| next_pc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Registered flag: control left the sequential path |
| link_we_o | output | 1 | Registered write enable for the return-address register |
| link_idx_o | output | 5 | Index of the return-address register (fixed at 31) |
| link_wdata_o | output | 32 | Registered return address (`pc_i + 4`) |

## Verification
The zero tests are tried with a positive value, zero, a negative value, the most negative value and the largest positive value. Together these separate a sign-bit test from an all-zero test and catch an unsigned or off-by-one compare. The equality tests use operands that are equal and operands that differ in a single low or high bit. Branch offsets of +16, -1 and the extreme positive and negative values show whether the offset is sign-extended, scaled by four and added to the sequential address rather than to the current one. A jump from an address with high bits set shows that the upper region bits are kept. A change of `rt_val_i` during a zero test and the unused kind codes show that neither touches the result.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Holds the kind encoding and the widths shared by the next-PC unit and its
// submodules. The encoding is fixed: the decode stage produces these codes.
package npc_pkg;
    localparam int XLEN       = 32;
    localparam int IMM_W      = 16;
    localparam int JT_W       = 26;
    localparam int IDX_W      = 5;
    localparam int INSN_BYTES = 4;

    typedef enum logic [3:0] {
        K_SEQ  = 4'd0,
        K_BEQ  = 4'd1,
        K_BNE  = 4'd2,
        K_BGTZ = 4'd3,
        K_BGEZ = 4'd4,
        K_BLTZ = 4'd5,
        K_BLEZ = 4'd6,
        K_JMP  = 4'd7,
        K_JAL  = 4'd8,
        K_JR   = 4'd9,
        K_JALR = 4'd10
    } ctl_kind_e;
endpackage

// File: rtl/npc_cond_eval.sv
// Module npc_cond_eval
// Decides whether a conditional branch holds. Equality uses a bitwise compare.
// The zero tests use only the sign bit and an all-zero reduction, so there is
// no subtractor. Assumes kind is already decoded; non-branch kinds give 0.
module npc_cond_eval #(
    parameter int W = 32
) (
    input  npc_pkg::ctl_kind_e kind,
    input  logic [W-1:0]       a_val,
    input  logic [W-1:0]       b_val,
    output logic               cond_true
);
    logic is_eq;
    logic is_zero;
    logic is_neg;

    // Shared condition flags, none of which needs an adder
    always_comb begin
        is_eq   = (a_val == b_val);
        is_zero = ~|a_val;
        is_neg  = a_val[W-1];
    end

    // Pick the flag combination for the decoded branch kind
    always_comb begin
        unique case (kind)
            npc_pkg::K_BEQ:  cond_true = is_eq;
            npc_pkg::K_BNE:  cond_true = ~is_eq;
            npc_pkg::K_BGTZ: cond_true = ~is_neg & ~is_zero;
            npc_pkg::K_BGEZ: cond_true = ~is_neg;
            npc_pkg::K_BLTZ: cond_true = is_neg;
            npc_pkg::K_BLEZ: cond_true = is_neg | is_zero;
            default:         cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
// Module npc_target_gen
// Forms the three candidate addresses: the sequential address, the
// PC-relative branch target and the region-absolute jump target.
// Assumes W > JT_W + 2 so that at least one region bit is left.
module npc_target_gen #(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int JT_W  = 26,
    parameter int STEP  = 4
) (
    input  logic [W-1:0]     pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JT_W-1:0]  jt,
    output logic [W-1:0]     seq_pc,
    output logic [W-1:0]     br_pc,
    output logic [W-1:0]     abs_pc
);
    localparam int REGION_W = W - JT_W - 2;
    localparam int EXT_W    = W - IMM_W - 2;

    logic [W-1:0] off_scaled;

    // Sequential address and the sign-extended, word-scaled offset
    always_comb begin
        seq_pc     = pc + W'(STEP);
        off_scaled = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    end

    // Branch target relative to the sequential address; jump keeps region bits
    always_comb begin
        br_pc  = seq_pc + off_scaled;
        abs_pc = {seq_pc[W-1 -: REGION_W], jt, 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
// Module npc_select
// Chooses the next address and the taken and link flags from the kind, the
// branch condition and the candidate targets. Unused codes count as sequential.
module npc_select #(
    parameter int W = 32
) (
    input  npc_pkg::ctl_kind_e kind,
    input  logic               cond_true,
    input  logic [W-1:0]       seq_pc,
    input  logic [W-1:0]       br_pc,
    input  logic [W-1:0]       abs_pc,
    input  logic [W-1:0]       reg_pc,
    output logic [W-1:0]       next_pc,
    output logic               taken,
    output logic               link_we
);
    // Target multiplexer and flags, one arm per group of kinds
    always_comb begin
        next_pc = seq_pc;
        taken   = 1'b0;
        link_we = 1'b0;
        case (kind)
            npc_pkg::K_BEQ, npc_pkg::K_BNE, npc_pkg::K_BGTZ,
            npc_pkg::K_BGEZ, npc_pkg::K_BLTZ, npc_pkg::K_BLEZ: begin
                taken   = cond_true;
                next_pc = cond_true ? br_pc : seq_pc;
            end
            npc_pkg::K_JMP: begin
                taken   = 1'b1;
                next_pc = abs_pc;
            end
            npc_pkg::K_JAL: begin
                taken   = 1'b1;
                link_we = 1'b1;
                next_pc = abs_pc;
            end
            npc_pkg::K_JR: begin
                taken   = 1'b1;
                next_pc = reg_pc;
            end
            npc_pkg::K_JALR: begin
                taken   = 1'b1;
                link_we = 1'b1;
                next_pc = reg_pc;
            end
            default: begin
                next_pc = seq_pc;
            end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
// Module npc_unit (top)
// Registered next-PC unit. It evaluates the branch condition, forms the
// candidate targets, selects one and registers the result with the link
// write. Synchronous active-low reset. Assumes kind_i is decoded upstream.
module npc_unit #(
    parameter int          XLEN     = npc_pkg::XLEN,
    parameter int          IMM_W    = npc_pkg::IMM_W,
    parameter int          JT_W     = npc_pkg::JT_W,
    parameter int          IDX_W    = npc_pkg::IDX_W,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [3:0]       kind_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [JT_W-1:0]  jtarget_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             taken_o,
    output logic             link_we_o,
    output logic [IDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]  link_wdata_o
);
    npc_pkg::ctl_kind_e kind;
    logic               cond_true;
    logic [XLEN-1:0]    seq_pc;
    logic [XLEN-1:0]    br_pc;
    logic [XLEN-1:0]    abs_pc;
    logic [XLEN-1:0]    nxt_d;
    logic               taken_d;
    logic               link_d;

    // Map the raw kind code onto the shared encoding
    always_comb kind = npc_pkg::ctl_kind_e'(kind_i);

    npc_cond_eval #(.W(XLEN)) u_cond (
        .kind      (kind),
        .a_val     (rs_val_i),
        .b_val     (rt_val_i),
        .cond_true (cond_true)
    );

    npc_target_gen #(
        .W     (XLEN),
        .IMM_W (IMM_W),
        .JT_W  (JT_W),
        .STEP  (npc_pkg::INSN_BYTES)
    ) u_tgt (
        .pc     (pc_i),
        .imm    (imm_i),
        .jt     (jtarget_i),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .abs_pc (abs_pc)
    );

    npc_select #(.W(XLEN)) u_sel (
        .kind      (kind),
        .cond_true (cond_true),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .abs_pc    (abs_pc),
        .reg_pc    (rs_val_i),
        .next_pc   (nxt_d),
        .taken     (taken_d),
        .link_we   (link_d)
    );

    // The link destination is a fixed architectural register
    always_comb link_idx_o = IDX_W'(LINK_REG);

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o    <= XLEN'(RESET_PC);
            taken_o      <= 1'b0;
            link_we_o    <= 1'b0;
            link_wdata_o <= '0;
        end else begin
            next_pc_o    <= nxt_d;
            taken_o      <= taken_d;
            link_we_o    <= link_d;
            link_wdata_o <= seq_pc;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Assertion checker for npc_unit. It relates the registered outputs to the
// inputs of the previous cycle. Bound to every npc_unit instance below.
module npc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_i,
    input logic [3:0]      kind_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] rt_val_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_wdata_o
);
    // R3: sequential kind advances by one instruction with no flags
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 4'd0) |=> (next_pc_o == $past(pc_i) + XLEN'(4)) && !taken_o && !link_we_o);

    // R5: unequal operands never take the equality branch
    p_beq_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 4'd1 && rs_val_i != rt_val_i) |=> !taken_o && (next_pc_o == $past(pc_i) + XLEN'(4)));

    // R6: a negative operand always takes the less-than-zero branch
    p_bltz_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 4'd5 && rs_val_i[XLEN-1]) |=> taken_o);

    // R8: register jump lands on the operand value
    p_jr_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 4'd9) |=> taken_o && (next_pc_o == $past(rs_val_i)));

    // R9: linking direct jump writes the return address
    p_jal_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 4'd8) |=> link_we_o && (link_wdata_o == $past(pc_i) + XLEN'(4)));

    // R10: a link write only ever comes with a taken transfer
    p_link_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> taken_o);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc_i),
    .kind_i       (kind_i),
    .rs_val_i     (rs_val_i),
    .rt_val_i     (rt_val_i),
    .next_pc_o    (next_pc_o),
    .taken_o      (taken_o),
    .link_we_o    (link_we_o),
    .link_wdata_o (link_wdata_o)
);

// File: tb/npc_unit_tb.sv
// Directed bench for npc_unit: one task per scenario, each checking itself.
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [3:0]  kind_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [15:0] imm_i = '0;
    logic [25:0] jtarget_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_wdata_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    npc_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_i         (pc_i),
        .kind_i       (kind_i),
        .rs_val_i     (rs_val_i),
        .rt_val_i     (rt_val_i),
        .imm_i        (imm_i),
        .jtarget_i    (jtarget_i),
        .next_pc_o    (next_pc_o),
        .taken_o      (taken_o),
        .link_we_o    (link_we_o),
        .link_idx_o   (link_idx_o),
        .link_wdata_o (link_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, capture on the rising edge, sample one unit later
    task automatic apply(input logic [3:0] k, input logic [31:0] pc,
                         input logic [31:0] rs, input logic [31:0] rt,
                         input logic [15:0] imm, input logic [25:0] jt);
        @(negedge clk);
        kind_i = k; pc_i = pc; rs_val_i = rs; rt_val_i = rt; imm_i = imm; jtarget_i = jt;
        @(posedge clk);
        #1;
    endtask

    // Branch check: condition from R5/R6, target from R4
    task automatic branch(input string req, input logic [3:0] k, input logic [31:0] pc,
                          input logic [31:0] rs, input logic [31:0] rt,
                          input logic [15:0] imm, input bit cond);
        logic [31:0] tgt;
        tgt = pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
        apply(k, pc, rs, rt, imm, 26'h0);
        chk(req, "taken", {31'd0, taken_o}, {31'd0, cond});
        chk("R4", "branch next_pc", next_pc_o, cond ? tgt : pc + 32'd4);
        chk("R10", "branch link_we", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(4'd7, 32'h1234_5670, 32'hFFFF_FFF0, 32'h0, 16'h1, 26'h3FF_FFFF);
        chk("R1", "next_pc", next_pc_o, 32'h0);
        chk("R1", "taken", {31'd0, taken_o}, 32'd0);
        chk("R1", "link_we", {31'd0, link_we_o}, 32'd0);
        chk("R1", "link_wdata", link_wdata_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sequential;
        apply(4'd0, 32'h0040_0010, 32'h5, 32'h5, 16'h0010, 26'h155);
        chk("R3", "next_pc", next_pc_o, 32'h0040_0014);
        chk("R3", "taken", {31'd0, taken_o}, 32'd0);
        chk("R3", "link_we", {31'd0, link_we_o}, 32'd0);
        // R2: output follows the most recent capture only
        apply(4'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h0);
        chk("R2", "wrap next_pc", next_pc_o, 32'h0000_0000);
    endtask

    task automatic t_equality;
        branch("R5", 4'd1, 32'h0040_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0010, 1'b1);
        branch("R5", 4'd1, 32'h0040_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 16'h0010, 1'b0);
        branch("R5", 4'd2, 32'h0040_0100, 32'h8000_0000, 32'h0000_0000, 16'hFFFF, 1'b1);
        branch("R5", 4'd2, 32'h0040_0100, 32'h7, 32'h7, 16'hFFFF, 1'b0);
        branch("R4", 4'd1, 32'h1000_0000, 32'h1, 32'h1, 16'h7FFF, 1'b1);
        branch("R4", 4'd1, 32'h1000_0000, 32'h1, 32'h1, 16'h8000, 1'b1);
    endtask

    task automatic t_zero_tests;
        // BGTZ (code 3)
        branch("R6", 4'd3, 32'h100, 32'h1, 32'h0, 16'h4, 1'b1);
        branch("R6", 4'd3, 32'h100, 32'h0, 32'h0, 16'h4, 1'b0);
        branch("R6", 4'd3, 32'h100, 32'h8000_0000, 32'h0, 16'h4, 1'b0);
        branch("R6", 4'd3, 32'h100, 32'h7FFF_FFFF, 32'h0, 16'h4, 1'b1);
        // BGEZ (code 4)
        branch("R6", 4'd4, 32'h200, 32'h0, 32'h0, 16'hFFF0, 1'b1);
        branch("R6", 4'd4, 32'h200, 32'hFFFF_FFFF, 32'h0, 16'hFFF0, 1'b0);
        // BLTZ (code 5)
        branch("R6", 4'd5, 32'h300, 32'h8000_0000, 32'h0, 16'h2, 1'b1);
        branch("R6", 4'd5, 32'h300, 32'h0, 32'h0, 16'h2, 1'b0);
        // BLEZ (code 6)
        branch("R6", 4'd6, 32'h400, 32'h0, 32'h0, 16'h8, 1'b1);
        branch("R6", 4'd6, 32'h400, 32'hFFFF_FFFE, 32'h0, 16'h8, 1'b1);
        branch("R6", 4'd6, 32'h400, 32'h1, 32'h0, 16'h8, 1'b0);
    endtask

    task automatic t_ignore_rt;
        // R11: the same zero test with a different rt must give the same result
        logic [31:0] first_pc;
        logic        first_tk;
        apply(4'd3, 32'h500, 32'h0, 32'h0, 16'h10, 26'h0);
        first_pc = next_pc_o; first_tk = taken_o;
        apply(4'd3, 32'h500, 32'h0, 32'hFFFF_FFFF, 16'h10, 26'h0);
        chk("R11", "next_pc with other rt", next_pc_o, first_pc);
        chk("R11", "taken with other rt", {31'd0, taken_o}, {31'd0, first_tk});
        chk("R11", "next_pc value", next_pc_o, 32'h504);
    endtask

    task automatic t_jumps;
        apply(4'd7, 32'hA000_0FF0, 32'h0, 32'h0, 16'h0, 26'h123_4567);
        chk("R7", "jump next_pc", next_pc_o, {4'hA, 26'h123_4567, 2'b00});
        chk("R10", "jump taken", {31'd0, taken_o}, 32'd1);
        chk("R10", "jump link_we", {31'd0, link_we_o}, 32'd0);
        // region bits come from pc+4, which crosses into the next region here
        apply(4'd7, 32'h1FFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h000_0001);
        chk("R7", "region from pc+4", next_pc_o, 32'h2000_0004);
        apply(4'd9, 32'h0040_0000, 32'h8765_4320, 32'h0, 16'h0, 26'h0);
        chk("R8", "reg jump next_pc", next_pc_o, 32'h8765_4320);
        chk("R8", "reg jump taken", {31'd0, taken_o}, 32'd1);
        chk("R10", "reg jump link_we", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_links;
        apply(4'd8, 32'hB000_0100, 32'h0, 32'h0, 16'h0, 26'h000_0040);
        chk("R9", "jal next_pc", next_pc_o, {4'hB, 26'h000_0040, 2'b00});
        chk("R9", "jal link_we", {31'd0, link_we_o}, 32'd1);
        chk("R9", "jal link_wdata", link_wdata_o, 32'hB000_0104);
        chk("R9", "link_idx", {27'd0, link_idx_o}, 32'd31);
        apply(4'd10, 32'h0000_2000, 32'h0000_3000, 32'h0, 16'h0, 26'h0);
        chk("R9", "jalr next_pc", next_pc_o, 32'h0000_3000);
        chk("R9", "jalr link_wdata", link_wdata_o, 32'h0000_2004);
        chk("R10", "jalr taken", {31'd0, taken_o}, 32'd1);
    endtask

    task automatic t_unused_codes;
        for (int c = 11; c < 16; c++) begin
            apply(4'(c), 32'h0000_0800, 32'h0000_0900, 32'h0000_0900, 16'h0040, 26'h3);
            chk("R12", "unused next_pc", next_pc_o, 32'h0000_0804);
            chk("R12", "unused taken", {31'd0, taken_o}, 32'd0);
            chk("R12", "unused link_we", {31'd0, link_we_o}, 32'd0);
        end
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_equality();
        t_zero_tests();
        t_ignore_rt();
        t_jumps();
        t_links();
        t_unused_codes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule